// File: doc/BRIEF.md
# Filtered Undervoltage Fault Reporter

This block watches raw undervoltage flags for a three-phase isolator gate driver and turns them into filtered status. One pair of flags describes the pumped gate supply: one says the supply is below its turn-on level and the other says it is below its lower drop-out level. One flag per phase says that phase's gate-source voltage is too low. The comparators that make these flags are outside the block, and the flags arrive synchronous to the clock.

The pump supply is declared good only after it has stayed above its turn-on level for a blanking time. It is declared bad again only after it has stayed below its drop-out level for a filter time. Each phase's gate voltage is watched only while that phase is being driven on, and it raises a fault after its own filter time. Any fault activates a pull-down on the shared enable line so that a controller can see the fault. The gates are never switched off by a fault. The block also reports which of three states the shared line is in: off, on, or on with a fault. When either of the two activation inputs is low, the device sleeps and all monitoring state is cleared.

Top module: `uvr_fault_reporter`

## Requirements
- R1: While the pump is good, `pump_good` falls and `pump_uv` rises at the clock edge that samples `cp_below_off`=1 for the CP_FILT_CYC-th consecutive cycle.
- R2: While awake and not good (after wake-up or after a pump undervoltage), `pump_good` rises at the edge that samples `cp_below_on`=0 for the CP_BLANK_CYC-th consecutive cycle. `pump_uv` is 1 whenever the device is awake and the pump is not good, including during blanking.
- R3: Hysteresis. While good, `cp_below_on` has no effect on the pump status. While not good, `cp_below_off` has no effect on it.
- R4: `phase_fault[i]` rises at the edge that samples `gs_low[i]`=1 together with `drive_on`=1 for the GS_FILT_CYC-th consecutive cycle. While `drive_on`=0, `gs_low` is ignored.
- R5: A set `phase_fault[i]` clears at the first edge that samples `gs_low[i]`=0 or `drive_on`=0.
- R6: `line_pull` (1 = open-drain pull-down active) equals `pump_uv` OR any `phase_fault` bit.
- R7: `drive_on` = `key_on` AND `supply_ok` AND `cmd_on`, whatever the fault state.
- R8: `line_state` encoding: 2'd0 off when `drive_on`=0; 2'd1 on when `drive_on`=1 and `line_pull`=0; 2'd2 fault when `drive_on`=1 and `line_pull`=1.
- R9: When a flag returns to good before its filter or blanking count completes, that count restarts from zero and no status changes.
- R10: When `key_on` or `supply_ok` is low, every count and fault is cleared at the next edge, `pump_good` is 0, and `pump_uv` and `line_pull` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_on | input | 1 | First activation input (switched supply present) |
| supply_ok | input | 1 | Second activation input (logic supply healthy) |
| cmd_on | input | 1 | Controller command: drive all gates on |
| cp_below_on | input | 1 | Pump supply below its turn-on level |
| cp_below_off | input | 1 | Pump supply below its drop-out level |
| gs_low | input | NPH | Per-phase gate-source undervoltage flags |
| pump_good | output | 1 | Pump supply blanked and above threshold |
| pump_uv | output | 1 | Pump undervoltage fault |
| phase_fault | output | NPH | Filtered per-phase gate-source fault |
| line_pull | output | 1 | Enable-line pull-down to fault level |
| line_state | output | 2 | Shared line state: 0 off, 1 on, 2 fault |
| drive_on | output | 1 | Gate outputs commanded on |

## Verification
`drive_on`, `line_state` and `line_pull` follow the inputs in the same cycle. `pump_good`, `pump_uv` and `phase_fault` change only at the edge that samples the last qualifying flag value, so they are visible one edge after that cycle's stimulus. The bench drives inputs on the falling edge and compares on the next falling edge. Its model advances its consecutive-cycle counts once per rising edge, which keeps expected and actual values aligned for both kinds of result. Directed sequences stop exactly one cycle short of each filter and blanking length and then one cycle past it. They also break a run one cycle before it would expire, to confirm that the count restarts.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef enum logic [1:0] {
    LINE_OFF   = 2'd0,
    LINE_ON    = 2'd1,
    LINE_FAULT = 2'd2
  } line_state_t;
endpackage

// File: rtl/uvr_persist.sv
// Consecutive-cycle persistence counter: hit is high in the cycle where cond
// has been true for LEN consecutive sampled cycles (including this one).
module uvr_persist #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic hit
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    hit    = cond && (cnt_q == LAST);
    cnt_en = cond || (cnt_q != '0);
    if (!cond || hit) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uvr_pump_mon.sv
// Pump supply monitor: blanking on the rising side, filter on the falling side.
module uvr_pump_mon #(
  parameter int unsigned FILT_CYC  = 100,
  parameter int unsigned BLANK_CYC = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake,
  input  logic below_on,
  input  logic below_off,
  output logic good
);
  logic good_q, good_d;
  logic blank_cond, blank_hit;
  logic drop_cond, drop_hit;

  // State selects which threshold flag is watched (hysteresis).
  assign blank_cond = awake && !good_q && !below_on;
  assign drop_cond  = awake &&  good_q &&  below_off;

  uvr_persist #(.LEN(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .cond(blank_cond), .hit(blank_hit)
  );

  uvr_persist #(.LEN(FILT_CYC)) u_drop (
    .clk(clk), .rst_n(rst_n), .cond(drop_cond), .hit(drop_hit)
  );

  always_comb begin
    good_d = good_q;
    if (!awake)                     good_d = 1'b0;
    else if (!good_q && blank_hit)  good_d = 1'b1;
    else if (good_q && drop_hit)    good_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= good_d;
  end

  assign good = good_q;
endmodule

// File: rtl/uvr_gate_mon.sv
// One phase gate-source monitor: filtered set, immediate clear.
module uvr_gate_mon #(
  parameter int unsigned FILT_CYC = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic watch,
  input  logic low,
  output logic fault
);
  logic cond, hit;
  logic fault_q, fault_d;

  assign cond = watch && low;

  uvr_persist #(.LEN(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .cond(cond), .hit(hit)
  );

  always_comb fault_d = cond && (fault_q || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_d;
  end

  assign fault = fault_q;
endmodule

// File: rtl/uvr_fault_reporter.sv
module uvr_fault_reporter #(
  parameter int unsigned NPH          = 3,
  parameter int unsigned CP_FILT_CYC  = 100,
  parameter int unsigned CP_BLANK_CYC = 800,
  parameter int unsigned GS_FILT_CYC  = 80
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           key_on,
  input  logic           supply_ok,
  input  logic           cmd_on,
  input  logic           cp_below_on,
  input  logic           cp_below_off,
  input  logic [NPH-1:0] gs_low,
  output logic           pump_good,
  output logic           pump_uv,
  output logic [NPH-1:0] phase_fault,
  output logic           line_pull,
  output logic [1:0]     line_state,
  output logic           drive_on
);
  import uvr_pkg::*;

  logic        awake;
  line_state_t state_c;

  assign awake    = key_on && supply_ok;
  assign drive_on = awake && cmd_on;

  uvr_pump_mon #(.FILT_CYC(CP_FILT_CYC), .BLANK_CYC(CP_BLANK_CYC)) u_pump (
    .clk(clk), .rst_n(rst_n), .awake(awake),
    .below_on(cp_below_on), .below_off(cp_below_off), .good(pump_good)
  );

  genvar g;
  generate
    for (g = 0; g < NPH; g++) begin : g_phase
      uvr_gate_mon #(.FILT_CYC(GS_FILT_CYC)) u_gate (
        .clk(clk), .rst_n(rst_n), .watch(drive_on),
        .low(gs_low[g]), .fault(phase_fault[g])
      );
    end
  endgenerate

  assign pump_uv   = awake && !pump_good;
  assign line_pull = pump_uv || (|phase_fault);

  always_comb begin
    if (!drive_on)      state_c = LINE_OFF;
    else if (line_pull) state_c = LINE_FAULT;
    else                state_c = LINE_ON;
  end

  assign line_state = state_c;
endmodule

// File: rtl/uvr_fault_reporter_chk.sv
module uvr_fault_reporter_chk #(
  parameter int unsigned NPH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           key_on,
  input logic           supply_ok,
  input logic           cp_below_on,
  input logic           cp_below_off,
  input logic [NPH-1:0] gs_low,
  input logic           pump_good,
  input logic [NPH-1:0] phase_fault,
  input logic           line_pull,
  input logic [1:0]     line_state,
  input logic           drive_on
);
  assert_good_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_good) |-> ($past(!cp_below_on) && $past(key_on && supply_ok)));

  assert_good_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pump_good) && $past(key_on && supply_ok)) |-> $past(cp_below_off));

  assert_phase_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_fault & ~$past(gs_low)) == '0);

  assert_sleep_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_on && supply_ok) |=> (!pump_good && (phase_fault == '0)));

  assert_fault_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pull && drive_on) |-> (line_state == 2'd2));
endmodule

bind uvr_fault_reporter uvr_fault_reporter_chk #(.NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_on(key_on), .supply_ok(supply_ok),
  .cp_below_on(cp_below_on), .cp_below_off(cp_below_off), .gs_low(gs_low),
  .pump_good(pump_good), .phase_fault(phase_fault), .line_pull(line_pull),
  .line_state(line_state), .drive_on(drive_on)
);

// File: tb/uvr_fault_reporter_test.sv
module uvr_fault_reporter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 3;
  localparam int CPF = 5;
  localparam int CPB = 12;
  localparam int GSF = 4;

  logic clk, rst_n, key_on, supply_ok, cmd_on, cp_below_on, cp_below_off;
  logic [NPH-1:0] gs_low, phase_fault;
  logic pump_good, pump_uv, line_pull, drive_on;
  logic [1:0] line_state;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit m_good;
  int m_blank, m_drop;
  int m_run[NPH];
  bit m_pf[NPH];

  uvr_fault_reporter #(.NPH(NPH), .CP_FILT_CYC(CPF), .CP_BLANK_CYC(CPB),
                       .GS_FILT_CYC(GSF)) uut (
    .clk(clk), .rst_n(rst_n), .key_on(key_on), .supply_ok(supply_ok),
    .cmd_on(cmd_on), .cp_below_on(cp_below_on), .cp_below_off(cp_below_off),
    .gs_low(gs_low), .pump_good(pump_good), .pump_uv(pump_uv),
    .phase_fault(phase_fault), .line_pull(line_pull),
    .line_state(line_state), .drive_on(drive_on)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit f_awake();
    return key_on && supply_ok;
  endfunction

  function automatic bit f_any_pf();
    bit a = 0;
    for (int i = 0; i < NPH; i++) a |= m_pf[i];
    return a;
  endfunction

  // Expected outputs from requirement formulas
  task automatic check_all();
    bit exp_uv, exp_pull, exp_drive;
    int exp_state;
    logic [NPH-1:0] exp_pf;
    exp_drive = f_awake() && cmd_on;
    exp_uv    = f_awake() && !m_good;
    exp_pull  = exp_uv || f_any_pf();
    exp_state = !exp_drive ? 0 : (exp_pull ? 2 : 1);
    for (int i = 0; i < NPH; i++) exp_pf[i] = m_pf[i];
    chk("R2 pump_good", pump_good, m_good);
    chk("R1 pump_uv", pump_uv, exp_uv);
    chk("R4 phase_fault", phase_fault, exp_pf);
    chk("R6 line_pull", line_pull, exp_pull);
    chk("R7 drive_on", drive_on, exp_drive);
    chk("R8 line_state", line_state, exp_state);
  endtask

  // Advance model by one rising edge using the currently applied inputs
  task automatic model_edge();
    bit aw, drv;
    aw  = f_awake();
    drv = aw && cmd_on;
    if (!aw) begin
      m_good = 0; m_blank = 0; m_drop = 0;
    end else if (!m_good) begin
      m_drop = 0;
      if (cp_below_on) m_blank = 0;
      else if (m_blank + 1 == CPB) begin m_good = 1; m_blank = 0; end
      else m_blank++;
    end else begin
      m_blank = 0;
      if (!cp_below_off) m_drop = 0;
      else if (m_drop + 1 == CPF) begin m_good = 0; m_drop = 0; end
      else m_drop++;
    end
    for (int i = 0; i < NPH; i++) begin
      if (!(drv && gs_low[i])) begin m_run[i] = 0; m_pf[i] = 0; end
      else if (m_pf[i]) m_run[i] = (m_run[i] + 1) % GSF;
      else if (m_run[i] + 1 == GSF) begin m_pf[i] = 1; m_run[i] = 0; end
      else m_run[i]++;
    end
  endtask

  // Called at a falling edge: apply inputs, step one cycle, compare
  task automatic step(input bit ko, input bit so, input bit cm, input bit bon,
                      input bit boff, input logic [NPH-1:0] gl);
    key_on = ko; supply_ok = so; cmd_on = cm;
    cp_below_on = bon; cp_below_off = boff; gs_low = gl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lvl, slp;
    void'($urandom(32'd4242));
    m_good = 0; m_blank = 0; m_drop = 0;
    for (int i = 0; i < NPH; i++) begin m_run[i] = 0; m_pf[i] = 0; end
    rst_n = 0; key_on = 0; supply_ok = 0; cmd_on = 0;
    cp_below_on = 1; cp_below_off = 1; gs_low = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset pump_good", pump_good, 0);
    chk("R10 reset line_state", line_state, 0);
    rst_n = 1;

    // R2 blanking: CPB-1 good cycles not enough
    for (int k = 0; k < CPB - 1; k++) step(1, 1, 1, 0, 0, '0);
    chk("R2 blank short pump_good", pump_good, 0);
    chk("R8 blank line_state fault", line_state, 2);
    // R9: one dip restarts blanking
    step(1, 1, 1, 1, 0, '0);
    for (int k = 0; k < CPB - 1; k++) step(1, 1, 1, 0, 0, '0);
    chk("R9 blank restart pump_good", pump_good, 0);
    step(1, 1, 1, 0, 0, '0);
    chk("R2 blank done pump_good", pump_good, 1);
    chk("R8 on line_state", line_state, 1);

    // R3: between thresholds while good has no effect
    for (int k = 0; k < 3 * CPF; k++) step(1, 1, 1, 1, 0, '0);
    chk("R3 hysteresis pump_good", pump_good, 1);

    // R9 drop filter restart, then R1 expiry
    for (int k = 0; k < CPF - 1; k++) step(1, 1, 1, 1, 1, '0);
    step(1, 1, 1, 1, 0, '0);
    for (int k = 0; k < CPF - 1; k++) step(1, 1, 1, 1, 1, '0);
    chk("R9 drop restart pump_good", pump_good, 1);
    step(1, 1, 1, 1, 1, '0);
    chk("R1 drop pump_uv", pump_uv, 1);
    chk("R6 drop line_pull", line_pull, 1);
    chk("R7 drive kept on fault", drive_on, 1);
    // R3: below_off ignored during blanking (only below_on matters)
    for (int k = 0; k < CPB; k++) step(1, 1, 1, 0, 1, '0);
    chk("R3 blank ignores below_off", pump_good, 1);

    // R4 phase filter / R5 immediate clear
    for (int k = 0; k < GSF - 1; k++) step(1, 1, 1, 0, 0, 3'b010);
    chk("R4 phase short", phase_fault, 3'b000);
    step(1, 1, 1, 0, 0, 3'b010);
    chk("R4 phase set", phase_fault, 3'b010);
    chk("R8 phase fault line_state", line_state, 2);
    step(1, 1, 1, 0, 0, 3'b000);
    chk("R5 phase clear", phase_fault, 3'b000);
    // R4: ignored while not driven
    for (int k = 0; k < 3 * GSF; k++) step(1, 1, 0, 0, 0, 3'b111);
    chk("R4 undriven ignored", phase_fault, 3'b000);
    chk("R8 off line_state", line_state, 0);
    for (int k = 0; k < GSF; k++) step(1, 1, 1, 0, 0, 3'b100);
    step(1, 1, 0, 0, 0, 3'b100);
    chk("R5 clear on command off", phase_fault, 3'b000);

    // R10 sleep
    step(1, 0, 1, 0, 0, '0);
    chk("R10 sleep pump_good", pump_good, 0);
    chk("R10 sleep line_pull", line_pull, 0);
    chk("R10 sleep drive_on", drive_on, 0);

    // Random stimulus
    lvl = 0; slp = 0;
    key_on = 1; supply_ok = 1; cmd_on = 1; gs_low = '0;
    for (int k = 0; k < 4000; k++) begin
      logic [NPH-1:0] g;
      bit ko, so, cm;
      if ($urandom % 16 == 0) lvl = $urandom % 3;
      ko = key_on; so = supply_ok; cm = cmd_on; g = gs_low;
      if ($urandom % 80 == 0) ko = !ko;
      if ($urandom % 80 == 0) so = !so;
      if (!(ko && so) && $urandom % 8 == 0) begin ko = 1; so = 1; end
      if ($urandom % 24 == 0) cm = !cm;
      for (int i = 0; i < NPH; i++) if ($urandom % 10 == 0) g[i] = !g[i];
      step(ko, so, cm, lvl != 0, lvl == 2, g);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule